// File: doc/BRIEF.md
# Edge-Interrupt GPIO Controller

This block provides sixteen general-purpose I/O lines behind a small register interface. Each line can be an input or an output. Output lines drive a latched data value. Input lines pass through a two-flop synchroniser. Software reads their levels through a per-pin gate, so a line whose gate bit is clear always reads as zero.

Each input line can raise an interrupt on one chosen edge, rising or falling, unless a per-pin mask blocks it. A detected edge sets a sticky flag. Software clears a flag by writing a 1 to its bit. One interrupt output is the OR of all the flags.

The bus is a single-cycle handshake made of valid, write, an access-size qualifier, an address and data. Only 16-bit accesses to the seven mapped word offsets do anything. Read data is combinational and is valid in the same cycle as the request.

Top module: `edge_gpio_ctrl`

## Requirements
- R1: The five writable registers hold the value written and read it back at their offsets: output latch 0x04, direction 0x08, edge choice 0x0C, mask 0x10, input gate 0x18.
- R2: A direction bit of 1 makes the pin an input and a 0 makes it an output. `pin_oe` is the inverse of direction. `pin_out` carries the output-latch bit on enabled pins and 0 on all other pins.
- R3: A legal write to direction or to the output latch changes `pin_oe` and `pin_out` in the first cycle after the write.
- R4: An edge-choice bit of 1 flags a low-to-high transition of the synchronised input. A bit of 0 flags a high-to-low transition. The flag, read at offset 0x14, becomes visible three clock edges after the pin changes.
- R5: An edge sets its flag only when the pin is an input (direction 1) and its mask bit is 0.
- R6: A write to 0x14 clears each flag written as 1 and leaves each flag written as 0 untouched. A new edge in the same cycle as a clear of that bit leaves the bit set.
- R7: `irq` is high exactly when at least one flag is set. It falls only after every flag has been cleared.
- R8: A read of 0x00 returns the synchronised inputs ANDed with the input gate. A pin change shows there after two clock edges. Writes to 0x00 change nothing.
- R9: After reset, the flags and the synchronised inputs are 0. The output latch, direction, edge choice, mask and input gate are all 0xFFFF, so `pin_oe` is 0 and `irq` is low.
- R10: An access with `bus_size16` low, or to any address other than the seven offsets (including misaligned ones), changes no state. Such a read returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_size16 | input | 1 | 1 when the access is 16 bits wide |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational, 0 when no legal read is made |
| pin_in | input | 16 | Asynchronous pin levels |
| pin_out | output | 16 | Output levels, 0 on pins that are not enabled |
| pin_oe | output | 16 | Per-pin output enable |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions take the bus fields as known whenever `bus_valid` is high, and they assume at most one access per cycle. They do not assume that `pin_in` is synchronous, because it enters through the synchroniser. They also assume that reset is held for at least one edge before any check applies. The stimulus changes every input on the falling clock edge and holds `pin_in` low through reset. It issues isolated single-cycle accesses. Edge events are spaced at least three edges apart, except in the one sequence that deliberately lines up a clear with a new edge on the same bit.

// File: rtl/edge_gpio_pkg.sv
package edge_gpio_pkg;

    localparam int GPIO_W = 16;
    localparam int ADDR_W = 8;

    typedef logic [GPIO_W-1:0] pinvec_t;

    localparam logic [ADDR_W-1:0] OFS_LEVEL = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_DRIVE = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_DIR   = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_EDGE  = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_MASK  = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_FLAG  = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_GATE  = 8'h18;

    typedef enum logic [2:0] {
        SEL_LEVEL,
        SEL_DRIVE,
        SEL_DIR,
        SEL_EDGE,
        SEL_MASK,
        SEL_FLAG,
        SEL_GATE,
        SEL_NONE
    } reg_sel_e;

    typedef struct packed {
        pinvec_t drive;
        pinvec_t dir;
        pinvec_t edge_sel;
        pinvec_t mask;
        pinvec_t gate;
    } cfg_t;

    localparam cfg_t CFG_RESET = '1;

    function automatic reg_sel_e decode_offset(input logic [ADDR_W-1:0] a);
        case (a)
            OFS_LEVEL: return SEL_LEVEL;
            OFS_DRIVE: return SEL_DRIVE;
            OFS_DIR:   return SEL_DIR;
            OFS_EDGE:  return SEL_EDGE;
            OFS_MASK:  return SEL_MASK;
            OFS_FLAG:  return SEL_FLAG;
            OFS_GATE:  return SEL_GATE;
            default:   return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/egc_input_stage.sv
module egc_input_stage #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pin_in,
    output logic [W-1:0] level,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    logic [W-1:0] meta_q;
    logic [W-1:0] level_q;
    logic [W-1:0] prev_q;

    // Two-flop synchroniser plus one history register for edge detection.
    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q  <= '0;
            level_q <= '0;
            prev_q  <= '0;
        end else begin
            meta_q  <= pin_in;
            level_q <= meta_q;
            prev_q  <= level_q;
        end
    end

    assign level = level_q;
    assign rise  = level_q & ~prev_q;
    assign fall  = ~level_q & prev_q;
endmodule

// File: rtl/egc_flag_unit.sv
module egc_flag_unit #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] rise,
    input  logic [W-1:0] fall,
    input  logic [W-1:0] edge_sel,
    input  logic [W-1:0] dir,
    input  logic [W-1:0] mask,
    input  logic         clr_en,
    input  logic [W-1:0] clr_bits,
    output logic [W-1:0] flags,
    output logic         irq
);
    logic [W-1:0] hit;
    logic [W-1:0] flag_q;
    logic [W-1:0] flag_next;
    logic         irq_q;

    for (genvar i = 0; i < W; i++) begin : g_hit
        assign hit[i] = dir[i] & ~mask[i] & (edge_sel[i] ? rise[i] : fall[i]);
    end

    // A fresh edge outranks a clear of the same bit in the same cycle.
    always_comb begin
        flag_next = flag_q;
        if (clr_en) flag_next = flag_next & ~clr_bits;
        flag_next = flag_next | hit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            flag_q <= flag_next;
            irq_q  <= |flag_next;
        end
    end

    assign flags = flag_q;
    assign irq   = irq_q;
endmodule

// File: rtl/edge_gpio_ctrl.sv
module edge_gpio_ctrl
    import edge_gpio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic              bus_size16,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [GPIO_W-1:0] bus_wdata,
    output logic [GPIO_W-1:0] bus_rdata,
    input  logic [GPIO_W-1:0] pin_in,
    output logic [GPIO_W-1:0] pin_out,
    output logic [GPIO_W-1:0] pin_oe,
    output logic              irq
);
    cfg_t     cfg;
    reg_sel_e sel;
    logic     acc_ok;
    logic     wr_en;
    logic     rd_en;
    pinvec_t  level;
    pinvec_t  rise;
    pinvec_t  fall;
    pinvec_t  flags;

    assign sel    = decode_offset(bus_addr);
    assign acc_ok = bus_valid & bus_size16 & (sel != SEL_NONE);
    assign wr_en  = acc_ok & bus_write;
    assign rd_en  = acc_ok & ~bus_write;

    egc_input_stage #(.W(GPIO_W)) u_in (
        .clk    (clk),
        .rst    (rst),
        .pin_in (pin_in),
        .level  (level),
        .rise   (rise),
        .fall   (fall)
    );

    egc_flag_unit #(.W(GPIO_W)) u_flag (
        .clk      (clk),
        .rst      (rst),
        .rise     (rise),
        .fall     (fall),
        .edge_sel (cfg.edge_sel),
        .dir      (cfg.dir),
        .mask     (cfg.mask),
        .clr_en   (wr_en && sel == SEL_FLAG),
        .clr_bits (bus_wdata),
        .flags    (flags),
        .irq      (irq)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= CFG_RESET;
        end else if (wr_en) begin
            case (sel)
                SEL_DRIVE: cfg.drive    <= bus_wdata;
                SEL_DIR:   cfg.dir      <= bus_wdata;
                SEL_EDGE:  cfg.edge_sel <= bus_wdata;
                SEL_MASK:  cfg.mask     <= bus_wdata;
                SEL_GATE:  cfg.gate     <= bus_wdata;
                default:   ;
            endcase
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (rd_en) begin
            case (sel)
                SEL_LEVEL: bus_rdata = level & cfg.gate;
                SEL_DRIVE: bus_rdata = cfg.drive;
                SEL_DIR:   bus_rdata = cfg.dir;
                SEL_EDGE:  bus_rdata = cfg.edge_sel;
                SEL_MASK:  bus_rdata = cfg.mask;
                SEL_FLAG:  bus_rdata = flags;
                SEL_GATE:  bus_rdata = cfg.gate;
                default:   bus_rdata = '0;
            endcase
        end
    end

    assign pin_oe  = ~cfg.dir;
    assign pin_out = cfg.drive & ~cfg.dir;
endmodule

// File: rtl/egc_checker.sv
module egc_checker
    import edge_gpio_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bus_valid,
    input logic              bus_write,
    input logic              bus_size16,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [GPIO_W-1:0] bus_wdata,
    input logic [GPIO_W-1:0] bus_rdata,
    input logic [GPIO_W-1:0] pin_out,
    input logic [GPIO_W-1:0] pin_oe,
    input logic              irq,
    input logic [GPIO_W-1:0] flag_q,
    input logic [GPIO_W-1:0] dir_q,
    input logic [GPIO_W-1:0] mask_q
);
    logic legal_wr;
    logic bad_wr;
    logic clr_wr;
    assign legal_wr = bus_valid && bus_write && bus_size16;
    assign bad_wr   = bus_valid && bus_write &&
                      (!bus_size16 || decode_offset(bus_addr) == SEL_NONE);
    assign clr_wr   = legal_wr && bus_addr == OFS_FLAG;

    assert_out_gated_R2: assert property (@(posedge clk) disable iff (rst)
        (pin_out & ~pin_oe) == '0);

    assert_dir_write_R3: assert property (@(posedge clk) disable iff (rst)
        (legal_wr && bus_addr == OFS_DIR) |=> pin_oe == ~$past(bus_wdata));

    assert_new_flag_legal_R5: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((flag_q & ~$past(flag_q)) & ($past(mask_q) | ~$past(dir_q))) == '0);

    assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        !clr_wr |=> (flag_q & $past(flag_q)) == $past(flag_q));

    assert_irq_matches_R7: assert property (@(posedge clk) disable iff (rst)
        irq == (flag_q != '0));

    assert_bad_write_R10: assert property (@(posedge clk) disable iff (rst)
        bad_wr |=> $stable(pin_oe) && $stable(pin_out));

    assert_bad_read_R10: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !bus_write && !bus_size16) |-> bus_rdata == '0);
endmodule

bind edge_gpio_ctrl egc_checker chk_i (
    .clk        (clk),
    .rst        (rst),
    .bus_valid  (bus_valid),
    .bus_write  (bus_write),
    .bus_size16 (bus_size16),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .pin_out    (pin_out),
    .pin_oe     (pin_oe),
    .irq        (irq),
    .flag_q     (flags),
    .dir_q      (cfg.dir),
    .mask_q     (cfg.mask)
);

// File: tb/edge_gpio_ctrl_tb_top.sv
`timescale 1ns/1ps
module edge_gpio_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic        bus_size16 = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [15:0] pin_in = '0;
    logic [15:0] pin_out;
    logic [15:0] pin_oe;
    logic        irq;

    int n_checks = 0;
    int n_err = 0;
    bit done = 0;

    always #4 clk = ~clk;

    edge_gpio_ctrl dut_i (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_size16(bus_size16), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_out(pin_out),
        .pin_oe(pin_oe), .irq(irq)
    );

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d, input logic sz = 1'b1);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d; bus_size16 = sz;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0; bus_size16 = 1'b1;
    endtask

    task automatic rd(input logic [7:0] a, output logic [15:0] d, input logic sz = 1'b1);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a; bus_size16 = sz;
        #1 d = bus_rdata;
        bus_valid = 1'b0; bus_size16 = 1'b1;
    endtask

    task automatic rd_check(input string req, input logic [7:0] a, input logic [15:0] exp);
        logic [15:0] d;
        rd(a, d);
        check(req, d, exp);
    endtask

    task automatic set_pins(input logic [15:0] v);
        @(negedge clk);
        pin_in = v;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset;
        rd_check("R9 level", 8'h00, 16'h0000);
        rd_check("R9 drive", 8'h04, 16'hFFFF);
        rd_check("R9 dir",   8'h08, 16'hFFFF);
        rd_check("R9 edge",  8'h0C, 16'hFFFF);
        rd_check("R9 mask",  8'h10, 16'hFFFF);
        rd_check("R9 flags", 8'h14, 16'h0000);
        rd_check("R9 gate",  8'h18, 16'hFFFF);
        check("R9 pin_oe", pin_oe, 16'h0000);
        check("R9 irq", {15'b0, irq}, 16'h0000);
    endtask

    task automatic t_regs;
        wr(8'h04, 16'h1357); wr(8'h08, 16'h0F0F); wr(8'h0C, 16'h3C3C);
        wr(8'h10, 16'h00FF); wr(8'h18, 16'hAAAA);
        rd_check("R1 drive", 8'h04, 16'h1357);
        rd_check("R1 dir",   8'h08, 16'h0F0F);
        rd_check("R1 edge",  8'h0C, 16'h3C3C);
        rd_check("R1 mask",  8'h10, 16'h00FF);
        rd_check("R1 gate",  8'h18, 16'hAAAA);
        wr(8'h10, 16'hFFFF); wr(8'h08, 16'hFFFF); wr(8'h18, 16'hFFFF);
    endtask

    task automatic t_outputs;
        wr(8'h04, 16'hA5C3);
        wr(8'h08, 16'hFF00);
        check("R3 oe after dir write", pin_oe, 16'h00FF);
        check("R2 out on enabled pins", pin_out, 16'h00C3);
        wr(8'h08, 16'h0FF0);
        check("R2 oe", pin_oe, 16'hF00F);
        check("R2 out", pin_out, 16'hA003);
        wr(8'h04, 16'h5A3C);
        check("R3 out after latch write", pin_out, 16'h500C);
        wr(8'h08, 16'hFFFF);
        check("R2 all inputs out", pin_out, 16'h0000);
    endtask

    task automatic t_level;
        logic [15:0] d;
        @(negedge clk);
        pin_in = 16'h1234;
        rd(8'h00, d);
        check("R8 one edge not yet visible", d, 16'h0000);
        rd(8'h00, d);
        check("R8 visible after two edges", d, 16'h1234);
        wr(8'h18, 16'h00FF);
        rd_check("R8 gated", 8'h00, 16'h0034);
        wr(8'h00, 16'hFFFF);
        rd_check("R8 write to level ignored", 8'h00, 16'h0034);
        rd_check("R8 dir untouched", 8'h08, 16'hFFFF);
        wr(8'h18, 16'hFFFF);
    endtask

    task automatic t_edges;
        set_pins(16'h0000);
        wr(8'h14, 16'hFFFF);
        wr(8'h0C, 16'h0005);
        wr(8'h10, 16'hFFF0);
        set_pins(16'h000F);
        rd_check("R4 rising pins 0,2", 8'h14, 16'h0005);
        check("R7 irq up", {15'b0, irq}, 16'h0001);
        set_pins(16'h0000);
        rd_check("R4 falling pins 1,3", 8'h14, 16'h000F);
        wr(8'h10, 16'hFFD0);
        wr(8'h08, 16'hFFDF);
        set_pins(16'h0030);
        set_pins(16'h0000);
        rd_check("R5 masked and output pins ignored", 8'h14, 16'h000F);
        wr(8'h14, 16'h0001);
        rd_check("R6 partial clear", 8'h14, 16'h000E);
        check("R7 irq stays", {15'b0, irq}, 16'h0001);
        wr(8'h14, 16'h000E);
        rd_check("R6 full clear", 8'h14, 16'h0000);
        check("R7 irq drops", {15'b0, irq}, 16'h0000);
        wr(8'h08, 16'hFFFF);
    endtask

    task automatic t_set_wins;
        set_pins(16'h0001);
        rd_check("R6 bit0 set", 8'h14, 16'h0001);
        set_pins(16'h0000);
        @(negedge clk); pin_in = 16'h0001;
        @(negedge clk);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 8'h14; bus_wdata = 16'h0001;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
        rd_check("R6 new edge beats clear", 8'h14, 16'h0001);
        wr(8'h14, 16'hFFFF);
        rd_check("R6 cleared after", 8'h14, 16'h0000);
        wr(8'h10, 16'hFFFF);
    endtask

    task automatic t_bad;
        logic [15:0] d;
        wr(8'h08, 16'h1234);
        wr(8'h08, 16'h0000, 1'b0);
        rd_check("R10 narrow write ignored", 8'h08, 16'h1234);
        check("R10 oe unchanged", pin_oe, 16'hEDCB);
        wr(8'h1C, 16'h0000);
        wr(8'h09, 16'h0000);
        rd_check("R10 unmapped write ignored", 8'h08, 16'h1234);
        rd(8'h08, d, 1'b0);
        check("R10 narrow read zero", d, 16'h0000);
        rd_check("R10 unmapped read zero", 8'h1C, 16'h0000);
        rd_check("R10 misaligned read zero", 8'h0A, 16'h0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_regs();
        t_outputs();
        t_level();
        t_edges();
        t_set_wins();
        t_bad();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end
endmodule